// File: doc/BRIEF.md
# Time-Triggered Sync Pulse Generator

This block turns a shared 64-bit nanosecond time value into two trigger outputs. It compares the time against per-channel programmed targets, not against a local divider. Each channel holds a start time, a cycle time, a pulse width and an activation bit, all loaded through a narrow write-only configuration port. When an active channel sees the time reach its target, it drives its output high. The channel then either stops or moves its target forward by the cycle time. A pulse lasts a programmed number of nanoseconds. Alternatively it can be held until software writes an acknowledge.

Every firing also sets a per-channel interrupt flag. The flags are ORed onto one request line toward a local processor. The second channel can optionally be slaved to the first, so that it fires together with every Nth firing of channel 0.

Configuration writes use `cfg_sel` to pick the channel (0 or 1) and `cfg_field` to pick the item. The item codes are: 0 control (bit 0 = activate), 1 start time, 2 cycle time, 3 pulse width, 4 acknowledge (data ignored), 5 divide ratio (channel 1 only). Writing the control item with bit 0 set re-arms the channel from its stored start time.

Top module: `tsync_gen`

## Requirements
- R1: After reset both sync outputs and the interrupt line are low, and they stay low while no channel is activated.
- R2: An active, armed channel drives its output high in the clock after the first edge at which the sampled time is greater than or equal to its current target, and it sets its interrupt flag at the same moment.
- R3: A target is never skipped when the time advances by several nanoseconds per clock; the trigger is taken at the first sample at or beyond it.
- R4: With a cycle time of zero the channel fires exactly once after activation.
- R5: With a nonzero cycle time the targets are start, start+cycle, start+2·cycle and so on, each computed from the previous target rather than from the sampled time.
- R6: With a nonzero pulse width W the output falls after the first edge whose sampled time is at or beyond target+W.
- R7: A pulse width of zero selects acknowledge mode: the output stays high until an acknowledge write (item 4) to that channel, then falls in the next clock.
- R8: `irq_o` is the OR of the two channel flags; an acknowledge write clears only the addressed channel's flag.
- R9: A control write with bit 0 clear drops that channel's output and flag in the next clock, and the channel triggers no more until it is activated again.
- R10: When item 5 of channel 1 holds N ≠ 0, channel 1 ignores its own start and cycle values and fires in the same clock as every Nth firing of channel 0, counted from channel 1's last control write. Its pulse width is then measured from the sampled time of that firing.
- R11: The two channels run concurrently, and the settings of one do not change the firing times of the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sys_time | input | 64 | Network-synchronised time in nanoseconds |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | Channel select, 0 or 1 |
| cfg_field | input | 3 | Item code of the write |
| cfg_wdata | input | 64 | Write data |
| sync_o | output | 2 | Trigger outputs, bit 0 = channel 0 |
| irq_o | output | 1 | Interrupt request toward the local processor |

## Verification
The assertions check the following on every cycle:
- a rising output in self-timed mode always follows a sample at or past the target;
- every rise carries the interrupt flag;
- a held acknowledge-mode pulse does not fall on its own;
- deactivation clears the output and the flag in the next clock;
- the divide counter stays below its ratio, and a slaved channel 1 firing coincides with a channel 0 firing.

Only the bench's scenarios can show the exact rise and fall times. These include targets missed by coarse time steps and cyclic spacing measured from targets. The scenarios also cover the single-shot count, selective acknowledge of the shared interrupt line, and the 1-in-N pattern of the slaved channel.

// File: rtl/tsync_pkg.sv
package tsync_pkg;

  typedef enum logic [2:0] {
    FLD_CTRL   = 3'd0,
    FLD_START  = 3'd1,
    FLD_CYCLE  = 3'd2,
    FLD_WIDTH  = 3'd3,
    FLD_ACK    = 3'd4,
    FLD_DIVIDE = 3'd5
  } cfg_field_e;

  localparam int unsigned CFG_FIELD_W = 3;

endpackage

// File: rtl/tsync_div.sv
module tsync_div #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_div,
  input  logic [DIV_W-1:0] wdata,
  input  logic             clear,
  input  logic             src_fire,
  output logic             ext_mode,
  output logic             ext_fire
);

  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic             last_slot;

  assign ext_mode  = (div_q != '0);
  assign last_slot = (cnt_q == div_q - 1'b1);
  assign ext_fire  = ext_mode && src_fire && last_slot;

  always_comb begin
    cnt_d = cnt_q;
    if (clear || wr_div) begin
      cnt_d = '0;
    end else if (ext_mode && src_fire) begin
      cnt_d = last_slot ? '0 : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
      cnt_q <= '0;
    end else begin
      if (wr_div) begin
        div_q <= wdata;
      end
      cnt_q <= cnt_d;
    end
  end

  // R10: the slot counter never reaches the ratio while slaving is on
  assert_cnt_in_range_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ext_mode |-> (cnt_q < div_q));

endmodule

// File: rtl/tsync_chan.sv
module tsync_chan #(
  parameter int unsigned TIME_W = 64,
  parameter int unsigned CYC_W  = 32,
  parameter int unsigned PW_W   = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TIME_W-1:0] sys_time,
  input  logic              wr_ctrl,
  input  logic              wr_start,
  input  logic              wr_cycle,
  input  logic              wr_width,
  input  logic              wr_ack,
  input  logic [TIME_W-1:0] wdata,
  input  logic              ext_mode,
  input  logic              ext_fire,
  output logic              fire_o,
  output logic              sync_o,
  output logic              irq_o
);

  logic [TIME_W-1:0] start_q;
  logic [CYC_W-1:0]  cycle_q;
  logic [PW_W-1:0]   width_q;

  logic              active_q, active_d;
  logic              armed_q,  armed_d;
  logic              out_q,    out_d;
  logic              irq_q,    irq_d;
  logic [TIME_W-1:0] next_q,   next_d;
  logic [TIME_W-1:0] end_q,    end_d;

  logic              time_hit;
  logic              fire;
  logic              ack_mode;
  logic              pulse_done;
  logic [TIME_W-1:0] base_time;

  assign time_hit   = (sys_time >= next_q);
  assign fire       = active_q && armed_q && (ext_mode ? ext_fire : time_hit);
  assign ack_mode   = (width_q == '0);
  assign pulse_done = out_q && !ack_mode && (sys_time >= end_q);
  assign base_time  = ext_mode ? sys_time : next_q;

  always_comb begin
    active_d = active_q;
    armed_d  = armed_q;
    out_d    = out_q;
    irq_d    = irq_q;
    next_d   = next_q;
    end_d    = end_q;
    if (wr_ctrl) begin
      active_d = wdata[0];
      armed_d  = wdata[0];
      next_d   = start_q;
      out_d    = 1'b0;
      irq_d    = 1'b0;
    end else if (active_q) begin
      if (pulse_done) begin
        out_d = 1'b0;
      end
      if (wr_ack) begin
        irq_d = 1'b0;
        if (ack_mode) begin
          out_d = 1'b0;
        end
      end
      if (fire) begin
        out_d = 1'b1;
        irq_d = 1'b1;
        end_d = base_time + TIME_W'(width_q);
        if (!ext_mode) begin
          if (cycle_q != '0) begin
            next_d = next_q + TIME_W'(cycle_q);
          end else begin
            armed_d = 1'b0;
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q  <= '0;
      cycle_q  <= '0;
      width_q  <= '0;
      active_q <= 1'b0;
      armed_q  <= 1'b0;
      out_q    <= 1'b0;
      irq_q    <= 1'b0;
      next_q   <= '0;
      end_q    <= '0;
    end else begin
      if (wr_start) begin
        start_q <= wdata;
      end
      if (wr_cycle) begin
        cycle_q <= wdata[CYC_W-1:0];
      end
      if (wr_width) begin
        width_q <= wdata[PW_W-1:0];
      end
      active_q <= active_d;
      armed_q  <= armed_d;
      out_q    <= out_d;
      irq_q    <= irq_d;
      next_q   <= next_d;
      end_q    <= end_d;
    end
  end

  assign fire_o = fire;
  assign sync_o = out_q;
  assign irq_o  = irq_q;

  // R2: a self-timed rise is always preceded by a sample at or past the target
  assert_rise_after_target_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(out_q) && !$past(ext_mode)) |-> $past(sys_time >= next_q));

  // R8: every rise comes with the interrupt flag set
  assert_rise_sets_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_q) |-> irq_q);

  // R4: a single-shot firing disarms the channel
  assert_single_disarm_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !ext_mode && cycle_q == '0 && !wr_ctrl) |=> !armed_q);

  // R7: in acknowledge mode the output stays up until acknowledged or stopped
  assert_ack_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && out_q && width_q == '0 && !wr_ack && !wr_ctrl) |=> out_q);

  // R9: stopping a channel clears its output and flag in the next clock
  assert_stop_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && !wdata[0]) |=> (!out_q && !irq_q));

endmodule

// File: rtl/tsync_gen.sv
module tsync_gen
  import tsync_pkg::*;
#(
  parameter int unsigned TIME_W = 64,
  parameter int unsigned CYC_W  = 32,
  parameter int unsigned PW_W   = 32,
  parameter int unsigned DIV_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TIME_W-1:0] sys_time,
  input  logic              cfg_we,
  input  logic              cfg_sel,
  input  logic [2:0]        cfg_field,
  input  logic [TIME_W-1:0] cfg_wdata,
  output logic [1:0]        sync_o,
  output logic              irq_o
);

  localparam int unsigned NCH = 2;

  logic [NCH-1:0] ext_mode_w;
  logic [NCH-1:0] ext_fire_w;
  logic [NCH-1:0] fire_w;
  logic [NCH-1:0] sync_w;
  logic [NCH-1:0] irq_w;
  logic [NCH-1:0] ch_hit;
  logic           wr_div;

  assign ext_mode_w[0] = 1'b0;
  assign ext_fire_w[0] = 1'b0;

  for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
    assign ch_hit[ch] = cfg_we && (cfg_sel == 1'(ch));

    tsync_chan #(
      .TIME_W (TIME_W),
      .CYC_W  (CYC_W),
      .PW_W   (PW_W)
    ) u_chan (
      .clk      (clk),
      .rst_n    (rst_n),
      .sys_time (sys_time),
      .wr_ctrl  (ch_hit[ch] && cfg_field == FLD_CTRL),
      .wr_start (ch_hit[ch] && cfg_field == FLD_START),
      .wr_cycle (ch_hit[ch] && cfg_field == FLD_CYCLE),
      .wr_width (ch_hit[ch] && cfg_field == FLD_WIDTH),
      .wr_ack   (ch_hit[ch] && cfg_field == FLD_ACK),
      .wdata    (cfg_wdata),
      .ext_mode (ext_mode_w[ch]),
      .ext_fire (ext_fire_w[ch]),
      .fire_o   (fire_w[ch]),
      .sync_o   (sync_w[ch]),
      .irq_o    (irq_w[ch])
    );
  end

  assign wr_div = ch_hit[1] && cfg_field == FLD_DIVIDE;

  tsync_div #(
    .DIV_W (DIV_W)
  ) u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_div   (wr_div),
    .wdata    (cfg_wdata[DIV_W-1:0]),
    .clear    (ch_hit[1] && cfg_field == FLD_CTRL),
    .src_fire (fire_w[0]),
    .ext_mode (ext_mode_w[1]),
    .ext_fire (ext_fire_w[1])
  );

  assign sync_o = sync_w;
  assign irq_o  = |irq_w;

  // R10: a slaved channel 1 only fires together with channel 0
  assert_slave_aligned_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_mode_w[1] && fire_w[1]) |-> fire_w[0]);

endmodule

// File: tb/tsync_gen_bench.sv
`timescale 1ns/1ps
module tsync_gen_bench;

  localparam int F_CTRL = 0, F_START = 1, F_CYCLE = 2, F_WIDTH = 3, F_ACK = 4, F_DIV = 5;
  localparam int WATCHDOG = 100000;

  typedef struct {
    longint unsigned rise;
    longint unsigned fall;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [63:0] sys_time;
  logic        cfg_we;
  logic        cfg_sel;
  logic [2:0]  cfg_field;
  logic [63:0] cfg_wdata;
  logic [1:0]  sync_o;
  logic        irq_o;

  int step;
  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 1'b0;
  string cur_tag = "R1";

  exp_t q0[$];
  exp_t q1[$];
  logic [1:0] prev_s;
  longint unsigned last_t;
  longint unsigned pend_fall [2];

  tsync_gen u_tsync_gen (
    .clk       (clk),
    .rst_n     (rst_n),
    .sys_time  (sys_time),
    .cfg_we    (cfg_we),
    .cfg_sel   (cfg_sel),
    .cfg_field (cfg_field),
    .cfg_wdata (cfg_wdata),
    .sync_o    (sync_o),
    .irq_o     (irq_o)
  );

  always #10 clk = ~clk;

  always @(posedge clk) begin
    if (!rst_n) sys_time <= 64'd0;
    else        sys_time <= sys_time + 64'(step);
  end

  task automatic check(bit ok, string tag, longint unsigned act, longint unsigned exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s [%s] actual=%0d expected=%0d", tag, cur_tag, act, exp);
    end
  endtask

  // driver side of the scoreboard
  task automatic push(int c, longint unsigned rise, longint unsigned fall);
    exp_t it;
    it.rise = rise;
    it.fall = fall;
    if (c == 0) q0.push_back(it);
    else        q1.push_back(it);
  endtask

  task automatic wr(int ch, int fld, longint unsigned d);
    @(negedge clk);
    cfg_we    = 1'b1;
    cfg_sel   = ch[0];
    cfg_field = fld[2:0];
    cfg_wdata = d;
    @(negedge clk);
    cfg_we    = 1'b0;
  endtask

  task automatic wait_until(longint unsigned x);
    while (sys_time < x) @(negedge clk);
  endtask

  function automatic longint unsigned first_ge(longint unsigned ref_t, longint unsigned x);
    longint unsigned s = longint'(step);
    if (x <= ref_t) return ref_t;
    return ref_t + ((x - ref_t + s - 1) / s) * s;
  endfunction

  // monitor side: last_t is the time the design sampled at the edge just passed
  task automatic mon(int c);
    exp_t it;
    bit s = sync_o[c];
    bit empty = (c == 0) ? (q0.size() == 0) : (q1.size() == 0);
    if (s && !prev_s[c]) begin
      if (empty) begin
        check(1'b0, c == 0 ? "R2 unexpected SYNC0 rise" : "R2 unexpected SYNC1 rise", last_t, 0);
      end else begin
        it = (c == 0) ? q0.pop_front() : q1.pop_front();
        check(last_t == it.rise, c == 0 ? "R2 SYNC0 rise time" : "R2 SYNC1 rise time", last_t, it.rise);
        pend_fall[c] = it.fall;
      end
    end else if (!s && prev_s[c] && pend_fall[c] != 0) begin
      check(last_t == pend_fall[c], c == 0 ? "R6 SYNC0 fall time" : "R6 SYNC1 fall time", last_t, pend_fall[c]);
      pend_fall[c] = 0;
    end
    prev_s[c] = s;
  endtask

  always @(negedge clk) begin
    if (rst_n === 1'b1) begin
      for (int c = 0; c < 2; c++) mon(c);
    end else begin
      prev_s = 2'b00;
    end
    last_t = sys_time;
  end

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles == WATCHDOG && !done) begin
      checks++;
      errors++;
      $display("FAIL watchdog [%s] actual=%0d expected=%0d", cur_tag, cycles, 0);
      summary();
    end
  end

  initial begin
    longint unsigned t, ref_t;
    rst_n = 1'b0;
    step = 1;
    cfg_we = 1'b0;
    cfg_sel = 1'b0;
    cfg_field = 3'd0;
    cfg_wdata = 64'd0;
    pend_fall[0] = 0;
    pend_fall[1] = 0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: idle after reset
    cur_tag = "R1";
    check(sync_o == 2'b00, "R1 sync after reset", sync_o, 0);
    check(irq_o == 1'b0, "R1 irq after reset", irq_o, 0);
    repeat (20) @(negedge clk);
    check(sync_o == 2'b00 && irq_o == 1'b0, "R1 idle without activation", {sync_o, irq_o}, 0);

    // R4, R6, R8, R11: two concurrent single shots
    cur_tag = "R11";
    t = sys_time;
    wr(0, F_START, t + 60); wr(0, F_CYCLE, 0); wr(0, F_WIDTH, 5); wr(0, F_CTRL, 1);
    wr(1, F_START, t + 67); wr(1, F_CYCLE, 0); wr(1, F_WIDTH, 6); wr(1, F_CTRL, 1);
    push(0, t + 60, t + 65);
    push(1, t + 67, t + 73);
    wait_until(t + 100);
    check(irq_o == 1'b1, "R8 irq raised by firing", irq_o, 1);
    wr(0, F_ACK, 0);
    check(irq_o == 1'b1, "R8 irq kept by other channel", irq_o, 1);
    wr(1, F_ACK, 0);
    check(irq_o == 1'b0, "R8 irq cleared after both acks", irq_o, 0);
    cur_tag = "R4";
    repeat (100) @(negedge clk);
    check(q0.size() == 0 && q1.size() == 0, "R4 single shots consumed", q0.size() + q1.size(), 0);
    check(sync_o == 2'b00, "R4 no refire", sync_o, 0);

    // R3, R5: cyclic with a coarse 3 ns step
    cur_tag = "R5";
    step = 3;
    @(negedge clk);
    ref_t = sys_time;
    t = ref_t + 90;
    wr(0, F_START, t + 1); wr(0, F_CYCLE, 10); wr(0, F_WIDTH, 4); wr(0, F_CTRL, 1);
    for (int k = 0; k < 3; k++) begin
      push(0, first_ge(ref_t, t + 1 + 10 * k), first_ge(ref_t, t + 1 + 10 * k + 4));
    end
    wait_until(t + 26);
    wr(0, F_CTRL, 0);
    check(q0.size() == 0, "R3 all coarse-step targets taken", q0.size(), 0);
    check(irq_o == 1'b0, "R9 stop clears irq", irq_o, 0);
    repeat (40) @(negedge clk);
    check(sync_o == 2'b00, "R5 no firing after stop", sync_o, 0);
    step = 1;
    @(negedge clk);

    // R7: acknowledge-held pulse
    cur_tag = "R7";
    t = sys_time;
    wr(1, F_START, t + 40); wr(1, F_CYCLE, 0); wr(1, F_WIDTH, 0); wr(1, F_CTRL, 1);
    push(1, t + 40, 0);
    wait_until(t + 60);
    check(sync_o[1] == 1'b1, "R7 held after firing", sync_o[1], 1);
    repeat (30) @(negedge clk);
    check(sync_o[1] == 1'b1, "R7 still held", sync_o[1], 1);
    wr(1, F_ACK, 0);
    check(sync_o[1] == 1'b0, "R7 released by ack", sync_o[1], 0);
    check(irq_o == 1'b0, "R8 ack clears flag", irq_o, 0);

    // R9: stop mid-pulse
    cur_tag = "R9";
    t = sys_time;
    wr(0, F_START, t + 40); wr(0, F_CYCLE, 30); wr(0, F_WIDTH, 8); wr(0, F_CTRL, 1);
    push(0, t + 40, 0);
    wait_until(t + 43);
    check(sync_o[0] == 1'b1, "R9 pulse active before stop", sync_o[0], 1);
    wr(0, F_CTRL, 0);
    check(sync_o[0] == 1'b0, "R9 stop drops output", sync_o[0], 0);
    check(irq_o == 1'b0, "R9 stop drops irq", irq_o, 0);
    repeat (100) @(negedge clk);
    check(q0.size() == 0 && sync_o == 2'b00, "R9 no trigger after stop", sync_o, 0);

    // R10: channel 1 slaved to every third channel 0 firing
    cur_tag = "R10";
    t = sys_time;
    wr(1, F_DIV, 3); wr(1, F_WIDTH, 2); wr(1, F_CTRL, 1);
    wr(0, F_START, t + 60); wr(0, F_CYCLE, 10); wr(0, F_WIDTH, 2); wr(0, F_CTRL, 1);
    for (int k = 0; k < 6; k++) push(0, t + 60 + 10 * k, t + 62 + 10 * k);
    push(1, t + 80, t + 82);
    push(1, t + 110, t + 112);
    wait_until(t + 115);
    wr(0, F_CTRL, 0);
    wr(1, F_CTRL, 0);
    check(q0.size() == 0, "R10 source firings seen", q0.size(), 0);
    check(q1.size() == 0, "R10 divided firings seen", q1.size(), 0);
    wr(1, F_DIV, 0);
    repeat (20) @(negedge clk);
    check(sync_o == 2'b00 && irq_o == 1'b0, "R10 quiet after stop", {sync_o, irq_o}, 0);

    done = 1'b1;
    summary();
  end

endmodule